// File: doc/BRIEF.md
# External Bus Area Decoder with Wait-State Timing

This block turns each external bus request into one access cycle against one of eight fixed address areas. It looks at the request address and picks an area. It drives that area's chip-select and reports the bus width and memory type configured for the area. It then holds the access open until every wait state has run out, and signals completion with a one-cycle `ready`. Addresses in the on-chip ROM/RAM region skip external timing completely: they finish in one cycle and are flagged as 32-bit.

The address is `ADDR_W` bits wide, 28 by default. With the defaults the address splits into the following regions:

| Address bits | Region |
|---|---|
| bit 27 set | on-chip memory |
| bits 27:25 all zero | the eight 4 MB areas, with the area number in bits 24:22 |
| bits 27:24 equal to `0010` | a 16 MB window that belongs to area 1, but only while area 1 is configured as DRAM |
| anything else | unmapped |

Each area has three configuration settings:
- a 16-bit width bit;
- a 2-bit memory type (`00` plain static memory, `01` DRAM, `10` multiplexed address/data, `11` plain);
- a 2-bit long-wait code, which only areas 0, 2 and 6 honour.

The active-high `wait_pin` input stretches an external access further.

Top module: `area_wait_ctl`

## Requirements
- R1: In the 8-area region (address bits 27:25 zero), the cycle after `req` is accepted, `cs` is one-hot with bit number equal to address bits 24:22. With no waits, `ready` is high in that same cycle.
- R2: An address with bits 27:24 equal to `0010` selects area 1 (`cs` = 8'h02) when bits 3:2 of `cfg_type` are `01` (DRAM). With any other type the address is unmapped.
- R3: An unmapped address drives no chip-select and returns `ready` in the cycle after `req`.
- R4: An on-chip address (bit 27 set) returns `ready` in the cycle after `req`, with `bus32` high and `cs` zero. It ignores `wait_pin` and the long-wait codes.
- R5: While an access is open, `bus16` equals the 16-bit width bit of the selected area.
- R6: Areas 0, 2 and 6 insert (long-wait code + 1) wait cycles before `wait_pin` is considered. All other areas insert none.
- R7: Once the long waits are used up, every cycle with `wait_pin` high delays `ready` by one further cycle.
- R8: `wait_act` is high in every cycle of an open access that does not give `ready`, and low otherwise.
- R9: At most one `cs` bit is ever high. All of them are low in the cycle after `ready`. A `req` that arrives while an access is open is ignored.
- R10: During an external access, `mem_type` carries the selected area's 2-bit type code. Otherwise it is `00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe, taken when idle |
| addr | input | ADDR_W | Access address |
| cfg_w16 | input | 8 | Per-area 16-bit width bit |
| cfg_type | input | 16 | Per-area 2-bit memory type |
| cfg_lwait | input | 16 | Per-area 2-bit long-wait code |
| wait_pin | input | 1 | External wait request, active high |
| cs | output | 8 | One-hot area select |
| bus16 | output | 1 | Selected area uses a 16-bit bus |
| bus32 | output | 1 | Current access is an on-chip 32-bit access |
| mem_type | output | 2 | Type code of the selected area |
| ready | output | 1 | Access completes this cycle |
| wait_act | output | 1 | Access is being stretched this cycle |

## Verification
Random accesses are spread across four address classes: area slots, the DRAM window, the on-chip range and unmapped space. Configurations and wait-pin hold lengths are random, so latency differences separate long-wait areas from plain ones, and on-chip accesses from external ones.

Directed cases cover specific corners:
- Each long-wait area is driven at code 0 and code 3.
- The DRAM window is tried with both DRAM and non-DRAM type codes, which separates a select from an unmapped result.
- A pin held high while an on-chip access runs must leave its single-cycle timing unchanged.
- A second request in the middle of an access must change neither its select nor its length.

// File: rtl/area_wait_ctl.sv
module area_wait_ctl #(
  parameter int ADDR_W   = 28,
  parameter int SPAN_W   = 22,
  parameter logic [7:0] LW_AREAS = 8'b0100_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cfg_w16,
  input  logic [15:0]       cfg_type,
  input  logic [15:0]       cfg_lwait,
  input  logic              wait_pin,
  output logic [7:0]        cs,
  output logic              bus16,
  output logic              bus32,
  output logic [1:0]        mem_type,
  output logic              ready,
  output logic              wait_act
);
  localparam int TOP_LO  = SPAN_W + 3;
  localparam int WIN_LO  = SPAN_W + 2;
  localparam logic [1:0] TYPE_DRAM = 2'b01;

  logic       busy, ext, chip, w16;
  logic [2:0] area, cnt;
  logic [1:0] typ;

  logic       d_chip, d_slot, d_win, d_ext;
  logic [2:0] d_area;
  logic [2:0] d_waits;

  assign d_chip  = addr[ADDR_W-1];
  assign d_slot  = !d_chip && (addr[ADDR_W-1:TOP_LO] == '0);
  assign d_win   = !d_chip && (addr[ADDR_W-1:WIN_LO] == {{(ADDR_W-WIN_LO-2){1'b0}}, 2'b10})
                   && (cfg_type[3:2] == TYPE_DRAM);
  assign d_ext   = d_slot || d_win;
  assign d_area  = d_slot ? addr[WIN_LO:SPAN_W] : 3'd1;
  assign d_waits = LW_AREAS[d_area] ? ({1'b0, cfg_lwait[2*d_area +: 2]} + 3'd1) : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ext  <= 1'b0;
      chip <= 1'b0;
      w16  <= 1'b0;
      area <= '0;
      cnt  <= '0;
      typ  <= '0;
    end else if (!busy) begin
      if (req) begin
        busy <= 1'b1;
        ext  <= d_ext;
        chip <= d_chip;
        area <= d_area;
        w16  <= d_ext && cfg_w16[d_area];
        typ  <= d_ext ? cfg_type[2*d_area +: 2] : 2'b00;
        cnt  <= d_ext ? d_waits : 3'd0;
      end
    end else if (ready) begin
      busy <= 1'b0;
      ext  <= 1'b0;
      chip <= 1'b0;
    end else if (cnt != 3'd0) begin
      cnt <= cnt - 3'd1;
    end
  end

  assign cs       = (busy && ext) ? (8'd1 << area) : 8'd0;
  assign ready    = busy && (!ext || (cnt == 3'd0 && !wait_pin));
  assign wait_act = busy && !ready;
  assign bus16    = busy && ext && w16;
  assign bus32    = busy && chip;
  assign mem_type = (busy && ext) ? typ : 2'b00;

  assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));
  assert_release_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (cs == 8'd0));
  assert_pin_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != 8'd0 && cnt == 3'd0 && wait_pin) |-> !ready);
  assert_longwait_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 3'd0) |-> (wait_act && cs != 8'd0));
  assert_onchip_nosel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus32 |-> (cs == 8'd0 && ready));
  assert_wait_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_act && ready));
endmodule

// File: tb/area_wait_ctl_tb.sv
module area_wait_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [27:0] addr = '0;
  logic [7:0]  cfg_w16 = '0;
  logic [15:0] cfg_type = '0;
  logic [15:0] cfg_lwait = '0;
  logic        wait_pin = 1'b0;
  logic [7:0]  cs;
  logic        bus16, bus32, ready, wait_act;
  logic [1:0]  mem_type;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  area_wait_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
    .cfg_w16(cfg_w16), .cfg_type(cfg_type), .cfg_lwait(cfg_lwait),
    .wait_pin(wait_pin), .cs(cs), .bus16(bus16), .bus32(bus32),
    .mem_type(mem_type), .ready(ready), .wait_act(wait_act)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_area(logic [27:0] a, logic [15:0] t);
    if (a[27]) return -1;
    if (a[27:25] == 3'b000) return int'(a[24:22]);
    if (a[27:24] == 4'b0010 && t[3:2] == 2'b01) return 1;
    return -1;
  endfunction

  function automatic int exp_sw(int ar, logic [15:0] lw);
    if (ar == 0 || ar == 2 || ar == 6) return int'(lw[2*ar +: 2]) + 1;
    return 0;
  endfunction

  task automatic access(logic [27:0] a, int pin_n, bit glitch);
    int ar, sw, lat, c;
    bit ext;
    ar  = exp_area(a, cfg_type);
    ext = (ar >= 0);
    sw  = ext ? exp_sw(ar, cfg_lwait) : 0;
    lat = ext ? sw + pin_n + 1 : 1;
    @(negedge clk);
    addr = a; req = 1'b1;
    c = 0;
    while (1) begin
      @(negedge clk);
      c++;
      req = (glitch && c == 1);
      if (glitch && c == 1) addr = a ^ 28'h0C00000;
      if (ext) wait_pin = (c > sw && c <= sw + pin_n);
      else     wait_pin = (pin_n > 0);
      #1;
      chk("R1/R2/R3 ready", ready, c == lat);
      chk("R8 wait_act", wait_act, c != lat);
      chk("R1/R2/R9 cs", cs, ext ? (32'd1 << ar) : 0);
      chk("R5 bus16", bus16, ext ? cfg_w16[ar] : 1'b0);
      chk("R4 bus32", bus32, a[27]);
      chk("R10 mem_type", mem_type, ext ? cfg_type[2*ar +: 2] : 2'b00);
      if (c >= lat || c > 40) break;
    end
    @(negedge clk);
    req = 1'b0; wait_pin = 1'b0;
    #1;
    chk("R9 cs cleared", cs, 0);
    chk("R9 idle ready", ready, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset cs", cs, 0);
    chk("R8 reset ready", ready, 0);
    @(negedge clk);
    rst_n = 1'b1;

    cfg_w16 = 8'b1010_0101; cfg_type = 16'h0000; cfg_lwait = 16'h0000;
    for (int i = 0; i < 8; i++) access({3'b000, i[2:0], 22'h1234}, 0, 1'b0); // R1 R5
    cfg_lwait = 16'hFFFF;
    access(28'h0000010, 0, 1'b0);            // R6 area 0 code 3
    access(28'h0800010, 2, 1'b0);            // R6 area 2 + R7
    access(28'h1800010, 1, 1'b0);            // R6 area 6 + R7
    access(28'h0400010, 3, 1'b0);            // R7 area 1 no long wait
    cfg_lwait = 16'h0000;
    access(28'h0000010, 0, 1'b0);            // R6 code 0
    cfg_type = 16'h0004;
    access(28'h20ABCDE, 0, 1'b0);            // R2 DRAM window selects area 1
    access(28'h2FFFFFF, 2, 1'b0);            // R2 top of window
    cfg_type = 16'h0008;
    access(28'h20ABCDE, 0, 1'b0);            // R2/R3 non-DRAM: unmapped
    access(28'h4000000, 0, 1'b0);            // R3 unmapped
    access(28'h8000100, 3, 1'b0);            // R4 on-chip ignores pin
    cfg_lwait = 16'hFFFF;
    access(28'h1800020, 2, 1'b1);            // R9 req during access ignored
    access(28'h8000000, 0, 1'b1);            // R9 on-chip glitch

    for (int k = 0; k < 300; k++) begin
      logic [27:0] a;
      int cls;
      cfg_w16   = 8'($urandom);
      cfg_type  = 16'($urandom);
      cfg_lwait = 16'($urandom);
      cls = $urandom_range(0, 3);
      a = 28'($urandom);
      case (cls)
        0: a[27:25] = 3'b000;
        1: a[27:24] = 4'b0010;
        2: a[27] = 1'b1;
        default: a[27:25] = 3'($urandom_range(1, 3));
      endcase
      access(a, $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule